// File: doc/BRIEF.md
# Quadrature Digital Downconverter with Numerically Controlled Oscillator

This block turns a stream of real ADC samples into in-phase and quadrature baseband products. The converter runs at 64 MHz and delivers one signed 16-bit sample per clock. The analog signal is a frequency-shift-keyed waveform on a 45 MHz carrier, which is above half the sample rate. Because it is undersampled, that carrier shows up in the sampled data as a 19 MHz tone. An on-chip oscillator generates sine and cosine at that 19 MHz alias, and two signed multipliers mix each sample with both. The pair of full-precision products comes out registered, together with a valid flag. Later filtering, decimation and demodulation are left to downstream blocks.

The oscillator is a phase accumulator. It advances by a fixed increment each time a valid sample is accepted. Its top bits address a quarter-wave magnitude table, and quadrant-folding logic rebuilds the full sine and cosine from that table. A product appears at the outputs a fixed number of clocks after its sample was presented.

Top module: `quad_ddc`

## Requirements
- R1: While the active-low asynchronous reset is asserted, `out_valid`, `i_out` and `q_out` are all zero and the phase accumulator is zero. As a result, the first valid sample after reset is mixed with phase code 0.
- R2: `out_valid` is high exactly 3 clocks after the clock edge that accepted a sample with `in_valid` high, and it is never high otherwise.
- R3: The 32-bit phase accumulator advances by the increment (default 19·2^26, which is 19 MHz at a 64 MHz rate) only on clocks that accept a valid sample. A sample offered with `in_valid` low changes neither the phase nor any output. Sample number k after reset (counting from 0) therefore uses phase code p = bits [31:22] of k·increment mod 2^32.
- R4: The quarter-wave table holds 256 entries. Entry j is round(511·sin(π·(j+0.5)/512)).
- R5: The 10-bit sine for phase code p is built as follows. Let quadrant = p[9:8] and index = p[7:0]. Odd quadrants use entry 255−index and even quadrants use entry index. The value is negated when p[9] is 1.
- R6: The cosine for phase code p equals the sine for phase code (p+256) mod 1024.
- R7: `i_out` is the exact 26-bit signed product of the sample and the sine. `q_out` is the exact 26-bit signed product of the sample and the cosine. This holds at the extremes −32768 and +32767.
- R8: `i_out` and `q_out` hold their values on every clock where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per cycle at most |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized upstream |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | 16 | Signed ADC sample |
| out_valid | output | 1 | Qualifies `i_out` and `q_out` |
| i_out | output | 26 | Signed sample × sine product |
| q_out | output | 26 | Signed sample × cosine product |

## Verification
The main risk is a wrong accumulator value, because it never corrects itself. Such an error shows up on the first valid product that follows it, as wrong `i_out` and `q_out` values 3 clocks after the affected sample, and every product after that stays wrong. An accumulator that steps on idle clocks, or that is not cleared by reset, shows up the same way on the first sample after the idle gap or after reset. A table or quadrant-folding fault shows up only at the phase codes it touches. For that reason the stream of samples is long enough to visit every phase code the increment reaches, in all four quadrants. A pipeline fault shows up as `out_valid` arriving on the wrong clock, or as outputs that move while `out_valid` is low.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  parameter int SAMP_W = 16;
  parameter int NCO_W  = 10;
  parameter int ACC_W  = 32;
  parameter int ADDR_W = 10;
  localparam int PROD_W = SAMP_W + NCO_W;
  localparam logic [ACC_W-1:0] DEF_INC = 32'd1275068416; // 19 * 2^26
endpackage

// File: rtl/ddc_phase_acc.sv
module ddc_phase_acc
  import ddc_pkg::*;
#(
  parameter int W  = ACC_W,
  parameter int AW = ADDR_W,
  parameter logic [W-1:0] INC = DEF_INC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] phase
);
  logic [W-1:0]  acc_q, acc_d;
  logic [AW-1:0] ph_q, ph_d;

  always_comb begin
    acc_d = acc_q;
    ph_d  = ph_q;
    if (adv) begin
      acc_d = acc_q + INC;
      ph_d  = acc_q[W-1 -: AW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
    end else begin
      acc_q <= acc_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc_q));
  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (acc_q == $past(acc_q) + INC));
endmodule

// File: rtl/ddc_sincos.sv
module ddc_sincos
  import ddc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int VW = NCO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [AW-1:0]        phase,
  output logic signed [VW-1:0] sin_o,
  output logic signed [VW-1:0] cos_o
);
  localparam int    QN  = 2 ** (AW - 2);
  localparam int    IW  = AW - 2;
  localparam int    MW  = VW - 1;
  localparam real   AMP = real'(2 ** (VW - 1) - 1);
  localparam real   PI  = 3.14159265358979323846;
  localparam logic [AW-1:0] QTR = {2'b01, {IW{1'b0}}};

  logic [MW-1:0] qtab [QN];

  for (genvar j = 0; j < QN; j++) begin : g_tab
    localparam int MAG = $rtoi(AMP * $sin(PI * (real'(j) + 0.5) / (2.0 * real'(QN))) + 0.5);
    assign qtab[j] = MAG[MW-1:0];
  end

  function automatic logic signed [VW-1:0] fold(input logic [AW-1:0] p,
                                                input logic [MW-1:0] m);
    logic signed [VW-1:0] v;
    v = $signed({1'b0, m});
    return p[AW-1] ? -v : v;
  endfunction

  logic [AW-1:0] cph;
  logic [IW-1:0] s_idx, c_idx;
  logic signed [VW-1:0] sin_d, cos_d, sin_q, cos_q;

  always_comb begin
    cph   = phase + QTR;
    s_idx = phase[AW-2] ? ~phase[IW-1:0] : phase[IW-1:0];
    c_idx = cph[AW-2]   ? ~cph[IW-1:0]   : cph[IW-1:0];
    sin_d = en ? fold(phase, qtab[s_idx]) : sin_q;
    cos_d = en ? fold(cph,   qtab[c_idx]) : cos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;

  // R5
  sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($past(phase[AW-1]) ? (sin_q < 0) : (sin_q > 0)));
  // R6
  cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($past(cph[AW-1]) ? (cos_q < 0) : (cos_q > 0)));
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
  import ddc_pkg::*;
#(
  parameter int SW = SAMP_W,
  parameter int VW = NCO_W,
  localparam int PW = SW + VW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] samp,
  input  logic signed [VW-1:0] sin_i,
  input  logic signed [VW-1:0] cos_i,
  output logic signed [PW-1:0] i_o,
  output logic signed [PW-1:0] q_o
);
  logic signed [PW-1:0] sx, sn, cs, i_d, q_d, i_q, q_q;

  always_comb begin
    sx  = $signed({{VW{samp[SW-1]}}, samp});
    sn  = $signed({{SW{sin_i[VW-1]}}, sin_i});
    cs  = $signed({{SW{cos_i[VW-1]}}, cos_i});
    i_d = en ? sx * sn : i_q;
    q_d = en ? sx * cs : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      q_q <= '0;
    end else begin
      i_q <= i_d;
      q_q <= q_d;
    end
  end

  assign i_o = i_q;
  assign q_o = q_q;

  // R7
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && samp == '0) |=> (i_q == '0 && q_q == '0));
endmodule

// File: rtl/quad_ddc.sv
module quad_ddc
  import ddc_pkg::*;
#(
  parameter int SW = SAMP_W,
  parameter int VW = NCO_W,
  parameter int AC = ACC_W,
  parameter int AW = ADDR_W,
  parameter logic [AC-1:0] INC = DEF_INC,
  localparam int PW = SW + VW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [PW-1:0] i_out,
  output logic signed [PW-1:0] q_out
);
  logic v1_q, v2_q, v3_q;
  logic signed [SW-1:0] s1_q, s2_q, s1_d, s2_d;
  logic [AW-1:0] ph1;
  logic signed [VW-1:0] sin2, cos2;

  always_comb begin
    s1_d = in_valid ? in_sample : s1_q;
    s2_d = v1_q     ? s1_q      : s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  ddc_phase_acc #(.W(AC), .AW(AW), .INC(INC)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .phase(ph1));

  ddc_sincos #(.AW(AW), .VW(VW)) u_lut (
    .clk(clk), .rst_n(rst_n), .en(v1_q), .phase(ph1),
    .sin_o(sin2), .cos_o(cos2));

  ddc_mixer #(.SW(SW), .VW(VW)) u_mix (
    .clk(clk), .rst_n(rst_n), .en(v2_q), .samp(s2_q),
    .sin_i(sin2), .cos_i(cos2), .i_o(i_out), .q_o(q_out));

  assign out_valid = v3_q;

  // R2
  out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(i_out) && $stable(q_out)));
endmodule

// File: tb/quad_ddc_tb.sv
module quad_ddc_tb;
  localparam real PI = 3.14159265358979323846;
  localparam logic [31:0] INC = 32'd1275068416;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [25:0] i_out, q_out;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] macc = '0;
  logic signed [25:0] last_i = '0, last_q = '0;

  int due_q[$];
  logic signed [25:0] ei_q[$], eq_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quad_ddc u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
                  .out_valid(out_valid), .i_out(i_out), .q_out(q_out));

  function automatic int qmag(int j);
    return $rtoi(511.0 * $sin(PI * (real'(j) + 0.5) / 512.0) + 0.5);
  endfunction

  function automatic int sin10(int p);
    int q = p / 256, idx = p % 256, m;
    m = (q % 2 == 1) ? qmag(255 - idx) : qmag(idx);
    return (q >= 2) ? -m : m;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic signed [15:0] s, string tag);
    int p;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s;
    p = int'(macc[31:22]);
    due_q.push_back(cyc + 3);
    ei_q.push_back(26'(longint'(s) * sin10(p)));
    eq_q.push_back(26'(longint'(s) * sin10((p + 256) % 1024)));
    tag_q.push_back(tag);
    macc = macc + INC;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 16'sh5A5A ^ 16'(k * 977); // junk, must be ignored (R3)
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (due_q.size() == 0) begin
          chk(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          chk(due_q[0] == cyc, "R2 latency", cyc, due_q[0]);
          chk(i_out == ei_q[0], {tag_q[0], " R5 R7 i_out"}, i_out, ei_q[0]);
          chk(q_out == eq_q[0], {tag_q[0], " R6 R7 q_out"}, q_out, eq_q[0]);
          void'(due_q.pop_front()); void'(ei_q.pop_front());
          void'(eq_q.pop_front()); void'(tag_q.pop_front());
        end
        last_i = i_out;
        last_q = q_out;
      end else begin
        if (due_q.size() != 0 && due_q[0] <= cyc)
          chk(1'b0, "R2 missing out_valid", 0, 1);
        chk(i_out == last_i && q_out == last_q, "R8 hold i_out", i_out, last_i);
      end
    end
  end

  task automatic reset_check();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(i_out == 0, "R1 i_out in reset", i_out, 0);
    chk(q_out == 0, "R1 q_out in reset", q_out, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    // R1: first sample after reset uses phase 0 (I=2, Q=511 for sample 1)
    send(16'sd1, "R1 R4");
    idle(4);
    chk(last_i == 26'sd2 && last_q == 26'sd511, "R1 R4 phase zero", last_i, 2);
    // back-to-back extremes over all reachable phases
    for (int k = 0; k < 64; k++) send((k % 2 == 0) ? -16'sd32768 : 16'sd32767, "R7 extreme");
    idle(3);
    // varied pattern with gaps (R3: idle clocks must not advance phase)
    for (int k = 0; k < 300; k++) begin
      send(16'(k * 4099 - 20000), "R3 R4");
      if (k % 7 == 3) idle(1 + k % 5);
    end
    send(16'sd0, "R7 zero");
    idle(10);
    // mid-run reset: accumulator and outputs return to zero
    @(negedge clk);
    rst_n = 1'b0;
    macc = '0;
    last_i = '0;
    last_q = '0;
    reset_check();
    rst_n = 1'b1;
    send(16'sd1, "R1 after reset");
    send(-16'sd1, "R1 second");
    idle(6);
    chk(due_q.size() == 0, "R2 all outputs seen", due_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule